// File: doc/BRIEF.md
# Multi-mode shift and rotate register

This block is a WIDTH-bit register (8 bits by default) with a one-bit carry flag. On every clock edge it performs exactly one operation selected by a 4-bit opcode. The operations are: keep the value, load a parallel word, a one-position shift in either direction, a rotate in either direction, and a rotate through the carry flag in either direction. Right shifts come in two forms, logical and arithmetic. No operation takes more than one cycle, and no operation moves the data by more than one bit.

Each shift takes its incoming bit from a serial input. A right shift fills the top bit from `shr_in`. A left shift fills the bottom bit from `shl_in`. The two edge bits of the register are always driven out on `shr_out` and `shl_out`. To build a wider shifter from two instances, feed the low part's `shr_in` from the high part's `shr_out`, and feed the high part's `shl_in` from the low part's `shl_out`. Then drive both parts with the same opcode. Tie a serial input to 0 to get a plain logical shift.

Top module: `mrot_shift_reg`

## Requirements
- R1: While `rst` is high at a rising edge, the data register and the carry flag both become 0, whatever the opcode is.
- R2: Opcode 1 (load) copies `par_in` into the register and leaves the carry flag unchanged.
- R3: Opcode 2 (logical right shift) moves every bit one place toward bit 0. The top bit takes `shr_in`, and the carry takes the old bit 0.
- R4: Opcode 3 (arithmetic right shift) moves every bit one place toward bit 0 and keeps the old top bit in the top position. The carry takes the old bit 0, and `shr_in` has no effect.
- R5: Opcode 4 (left shift) moves every bit one place toward the top. Bit 0 takes `shl_in`, and the carry takes the old top bit.
- R6: Opcode 5 (rotate right) puts the old bit 0 into the top position. Opcode 6 (rotate left) puts the old top bit into bit 0. In both cases the carry receives the bit that wrapped around, and the serial inputs have no effect.
- R7: Opcode 7 (rotate right through carry) puts the old carry into the top bit and the old bit 0 into the carry. Opcode 8 (rotate left through carry) puts the old carry into bit 0 and the old top bit into the carry.
- R8: Opcode 0 and every code from 9 to 15 keep both the register and the carry unchanged. `par_in` and the serial inputs have no effect under these codes.
- R9: `shr_out` always equals bit 0 of the register and `shl_out` always equals its top bit. Two instances chained through these outputs shift as one register of twice the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 4 | Operation code |
| par_in | input | WIDTH | Parallel load word |
| shr_in | input | 1 | Bit entering the top position on a right shift |
| shl_in | input | 1 | Bit entering bit 0 on a left shift |
| data_out | output | WIDTH | Register contents |
| carry_out | output | 1 | Carry flag |
| shr_out | output | 1 | Bit 0 of the register, for chaining right shifts |
| shl_out | output | 1 | Top bit of the register, for chaining left shifts |

## Verification
The rotates through carry are the hardest operations to reach. Their result depends on a carry value that a load can never set, because a load leaves the carry alone. To get a known carry, the stimulus first runs shifts and rotates that drive the carry to a chosen level, then loads a fresh word, and only then applies the rotates through carry with both carry values. The cascade case needs two instances chained through their serial pins. A word is loaded across both instances so that the bit crossing the boundary is a 1 in each direction.

// File: rtl/mrot_pkg.sv
package mrot_pkg;

    // Operation codes; any code not listed keeps the register as it is
    typedef enum logic [3:0] {
        OP_HOLD = 4'd0,
        OP_LOAD = 4'd1,
        OP_LSR  = 4'd2,
        OP_ASR  = 4'd3,
        OP_SL   = 4'd4,
        OP_ROR  = 4'd5,
        OP_ROL  = 4'd6,
        OP_RCR  = 4'd7,
        OP_RCL  = 4'd8
    } op_e;

    // Source picked by every bit's 4-way selector
    typedef enum logic [1:0] {
        SRC_KEEP  = 2'd0,
        SRC_UPPER = 2'd1,   // neighbour above (right move)
        SRC_LOWER = 2'd2,   // neighbour below (left move)
        SRC_PAR   = 2'd3
    } src_e;

    // Decoded control for one cycle
    typedef struct packed {
        src_e src;
        logic fill_top;     // bit entering the top on a right move
        logic fill_bot;     // bit entering bit 0 on a left move
        logic cy_write;
        logic cy_value;
    } ctrl_t;

endpackage

// File: rtl/mrot_op_decode.sv
module mrot_op_decode
    import mrot_pkg::*;
(
    input  logic [3:0] op,
    input  logic       top_bit,
    input  logic       bot_bit,
    input  logic       cy_now,
    input  logic       shr_in,
    input  logic       shl_in,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{src: SRC_KEEP, fill_top: 1'b0, fill_bot: 1'b0,
                 cy_write: 1'b0, cy_value: cy_now};
        case (op_e'(op))
            OP_LOAD: ctrl.src = SRC_PAR;
            OP_LSR: begin
                ctrl.src      = SRC_UPPER;
                ctrl.fill_top = shr_in;
                ctrl.cy_write = 1'b1;
                ctrl.cy_value = bot_bit;
            end
            OP_ASR: begin
                ctrl.src      = SRC_UPPER;
                ctrl.fill_top = top_bit;
                ctrl.cy_write = 1'b1;
                ctrl.cy_value = bot_bit;
            end
            OP_SL: begin
                ctrl.src      = SRC_LOWER;
                ctrl.fill_bot = shl_in;
                ctrl.cy_write = 1'b1;
                ctrl.cy_value = top_bit;
            end
            OP_ROR: begin
                ctrl.src      = SRC_UPPER;
                ctrl.fill_top = bot_bit;
                ctrl.cy_write = 1'b1;
                ctrl.cy_value = bot_bit;
            end
            OP_ROL: begin
                ctrl.src      = SRC_LOWER;
                ctrl.fill_bot = top_bit;
                ctrl.cy_write = 1'b1;
                ctrl.cy_value = top_bit;
            end
            OP_RCR: begin
                ctrl.src      = SRC_UPPER;
                ctrl.fill_top = cy_now;
                ctrl.cy_write = 1'b1;
                ctrl.cy_value = bot_bit;
            end
            OP_RCL: begin
                ctrl.src      = SRC_LOWER;
                ctrl.fill_bot = cy_now;
                ctrl.cy_write = 1'b1;
                ctrl.cy_value = top_bit;
            end
            default: ctrl.src = SRC_KEEP;
        endcase
    end

endmodule

// File: rtl/mrot_bit_mux.sv
module mrot_bit_mux
    import mrot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  src_e             src,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] par,
    input  logic             fill_top,
    input  logic             fill_bot,
    output logic [WIDTH-1:0] nxt
);

    localparam int TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic from_up;
        logic from_dn;
        if (i == TOP) begin : g_top
            assign from_up = fill_top;
        end else begin : g_mid_up
            assign from_up = cur[i+1];
        end
        if (i == 0) begin : g_bot
            assign from_dn = fill_bot;
        end else begin : g_mid_dn
            assign from_dn = cur[i-1];
        end
        always_comb begin
            case (src)
                SRC_UPPER: nxt[i] = from_up;
                SRC_LOWER: nxt[i] = from_dn;
                SRC_PAR:   nxt[i] = par[i];
                default:   nxt[i] = cur[i];
            endcase
        end
    end

endmodule

// File: rtl/mrot_shift_reg.sv
module mrot_shift_reg
    import mrot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] par_in,
    input  logic             shr_in,
    input  logic             shl_in,
    output logic [WIDTH-1:0] data_out,
    output logic             carry_out,
    output logic             shr_out,
    output logic             shl_out
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             cy;
    } state_t;

    state_t           st_d, st_q;
    ctrl_t            ctrl;
    logic [WIDTH-1:0] data_nxt;

    mrot_op_decode u_dec (
        .op      (op),
        .top_bit (st_q.data[TOP]),
        .bot_bit (st_q.data[0]),
        .cy_now  (st_q.cy),
        .shr_in  (shr_in),
        .shl_in  (shl_in),
        .ctrl    (ctrl)
    );

    mrot_bit_mux #(.WIDTH(WIDTH)) u_mux (
        .src      (ctrl.src),
        .cur      (st_q.data),
        .par      (par_in),
        .fill_top (ctrl.fill_top),
        .fill_bot (ctrl.fill_bot),
        .nxt      (data_nxt)
    );

    always_comb begin
        st_d.data = data_nxt;
        st_d.cy   = ctrl.cy_write ? ctrl.cy_value : st_q.cy;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign data_out  = st_q.data;
    assign carry_out = st_q.cy;
    assign shr_out   = st_q.data[0];
    assign shl_out   = st_q.data[TOP];

    // Checks on port behaviour across one edge
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (data_out == '0 && !carry_out));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!rst && op == OP_LOAD) |=> (data_out == $past(par_in) && carry_out == $past(carry_out)));

    assert_lsr_R3: assert property (@(posedge clk) disable iff (rst)
        (!rst && op == OP_LSR) |=> (data_out == {$past(shr_in), $past(data_out[TOP:1])}
                                    && carry_out == $past(data_out[0])));

    assert_asr_R4: assert property (@(posedge clk) disable iff (rst)
        (!rst && op == OP_ASR) |=> (data_out == {$past(data_out[TOP]), $past(data_out[TOP:1])}
                                    && carry_out == $past(data_out[0])));

    assert_sl_R5: assert property (@(posedge clk) disable iff (rst)
        (!rst && op == OP_SL) |=> (data_out == {$past(data_out[TOP-1:0]), $past(shl_in)}
                                   && carry_out == $past(data_out[TOP])));

    assert_ror_R6: assert property (@(posedge clk) disable iff (rst)
        (!rst && op == OP_ROR) |=> (data_out == {$past(data_out[0]), $past(data_out[TOP:1])}));

    assert_rcl_R7: assert property (@(posedge clk) disable iff (rst)
        (!rst && op == OP_RCL) |=> (data_out == {$past(data_out[TOP-1:0]), $past(carry_out)}
                                    && carry_out == $past(data_out[TOP])));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!rst && (op == OP_HOLD || op > OP_RCL)) |=> ($stable(data_out) && $stable(carry_out)));

    assert_edges_R9: assert property (@(posedge clk)
        shr_out == data_out[0] && shl_out == data_out[TOP]);

endmodule

// File: tb/mrot_shift_reg_test.sv
module mrot_shift_reg_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   op;
    logic [W-1:0] par_in;
    logic         shr_in, shl_in;
    logic [W-1:0] data_out;
    logic         carry_out, shr_out, shl_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    mrot_shift_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .op(op), .par_in(par_in),
        .shr_in(shr_in), .shl_in(shl_in), .data_out(data_out),
        .carry_out(carry_out), .shr_out(shr_out), .shl_out(shl_out)
    );

    // Two chained instances forming a 16-bit register (R9)
    logic [3:0]   c_op;
    logic [W-1:0] hi_par, lo_par, hi_q, lo_q;
    logic         hi_c, lo_c, hi_ro, hi_lo, lo_ro, lo_lo;

    mrot_shift_reg #(.WIDTH(W)) u_hi (
        .clk(clk), .rst(rst), .op(c_op), .par_in(hi_par),
        .shr_in(1'b0), .shl_in(lo_lo), .data_out(hi_q),
        .carry_out(hi_c), .shr_out(hi_ro), .shl_out(hi_lo)
    );
    mrot_shift_reg #(.WIDTH(W)) u_lo (
        .clk(clk), .rst(rst), .op(c_op), .par_in(lo_par),
        .shr_in(hi_ro), .shl_in(1'b0), .data_out(lo_q),
        .carry_out(lo_c), .shr_out(lo_ro), .shl_out(lo_lo)
    );

    // Vector: op, par_in, shr_in, shl_in, expected data, expected carry
    localparam int NV = 20;
    localparam logic [22:0] VEC [NV] = '{
        {4'd1, 8'hA5, 1'b0, 1'b0, 8'hA5, 1'b0},
        {4'd2, 8'h00, 1'b0, 1'b0, 8'h52, 1'b1},
        {4'd3, 8'h00, 1'b1, 1'b0, 8'h29, 1'b0},
        {4'd1, 8'h96, 1'b0, 1'b0, 8'h96, 1'b0},
        {4'd3, 8'h00, 1'b0, 1'b0, 8'hCB, 1'b0},
        {4'd3, 8'h00, 1'b0, 1'b1, 8'hE5, 1'b1},
        {4'd4, 8'h00, 1'b0, 1'b0, 8'hCA, 1'b1},
        {4'd4, 8'h00, 1'b0, 1'b1, 8'h95, 1'b1},
        {4'd5, 8'h00, 1'b0, 1'b0, 8'hCA, 1'b1},
        {4'd6, 8'h00, 1'b0, 1'b0, 8'h95, 1'b1},
        {4'd2, 8'h00, 1'b1, 1'b0, 8'hCA, 1'b1},
        {4'd1, 8'h01, 1'b0, 1'b0, 8'h01, 1'b1},
        {4'd7, 8'h00, 1'b0, 1'b0, 8'h80, 1'b1},
        {4'd7, 8'h00, 1'b0, 1'b0, 8'hC0, 1'b0},
        {4'd8, 8'h00, 1'b0, 1'b0, 8'h80, 1'b1},
        {4'd8, 8'h00, 1'b0, 1'b0, 8'h01, 1'b1},
        {4'd0, 8'hFF, 1'b1, 1'b1, 8'h01, 1'b1},
        {4'd9, 8'hFF, 1'b1, 1'b1, 8'h01, 1'b1},
        {4'd15, 8'hFF, 1'b1, 1'b1, 8'h01, 1'b1},
        {4'd6, 8'h00, 1'b1, 1'b1, 8'h02, 1'b0}
    };

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'd1:       return "R2";
            4'd2:       return "R3";
            4'd3:       return "R4";
            4'd4:       return "R5";
            4'd5, 4'd6: return "R6";
            4'd7, 4'd8: return "R7";
            default:    return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] aq, input logic [W-1:0] eq,
                         input logic ac, input logic ec);
        checks++;
        if (aq !== eq || ac !== ec) begin
            errors++;
            $display("FAIL %s: data=%h carry=%b, expected data=%h carry=%b", req, aq, ac, eq, ec);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; op = 4'd1; par_in = 8'hFF; shr_in = 1'b1; shl_in = 1'b1;
        c_op = 4'd0; hi_par = '0; lo_par = '0;
        repeat (3) @(negedge clk);
        // R1: reset wins over a load
        check("R1", data_out, 8'h00, carry_out, 1'b0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            op     = VEC[k][22:19];
            par_in = VEC[k][18:11];
            shr_in = VEC[k][10];
            shl_in = VEC[k][9];
            @(negedge clk);
            check(req_of(VEC[k][22:19]), data_out, VEC[k][8:1], carry_out, VEC[k][0]);
        end

        // R9: edge outputs follow the register
        op = 4'd1; par_in = 8'h81; @(negedge clk);
        check("R9", {6'd0, shl_out, shr_out}, 8'h03, carry_out, 1'b0);
        op = 4'd1; par_in = 8'h7E; @(negedge clk);
        check("R9", {6'd0, shl_out, shr_out}, 8'h00, carry_out, 1'b0);

        // R1: reset mid-run clears a set carry
        op = 4'd5; par_in = 8'h00; @(negedge clk);   // 7E -> 3F, carry 0
        op = 4'd1; par_in = 8'hFF; @(negedge clk);
        op = 4'd2; shr_in = 1'b0;  @(negedge clk);   // FF -> 7F, carry 1
        check("R3", data_out, 8'h7F, carry_out, 1'b1);
        rst = 1'b1; op = 4'd4; @(negedge clk);
        check("R1", data_out, 8'h00, carry_out, 1'b0);
        rst = 1'b0; op = 4'd0;

        // R9: chained pair shifts as 16 bits
        c_op = 4'd1; hi_par = 8'h81; lo_par = 8'h01; @(negedge clk);
        c_op = 4'd2; @(negedge clk);
        check("R9", hi_q, 8'h40, 1'b0, 1'b0);
        check("R9", lo_q, 8'h80, lo_c, 1'b1);
        c_op = 4'd4; @(negedge clk);
        check("R9", hi_q, 8'h81, hi_c, 1'b0);
        check("R9", lo_q, 8'h00, lo_c, 1'b1);
        c_op = 4'd0;

        finish_run();
    end

endmodule